// File: doc/BRIEF.md
# Serial Character Receiver with Optional Stop Bits

This block turns a serial input line into 8-bit characters. Each character starts with a low start bit and is followed by data bits, least significant bit first, and then a stop bit. A receive timer runs the sampling in one of two ways. In asynchronous mode each clock is one oversampling tick, and the ratio of ticks per bit is selectable as 8, 16 or 32. In synchronous mode every clock edge samples exactly one bit. Each received character appears on a data port together with a one-cycle valid pulse and two flags: framing error and break.

A stopless mode is available for synchronous links that drop stop bits to adapt rates. In this mode, when the stop position reads low, the block flags the character but keeps receiving. That low bit is taken as the start of the next character. Break is then reported only when two all-zero, stopless characters arrive back to back.

A gate input pair lets a neighbouring transmitter switch reception off while it drives a shared multidrop line. Any character in progress when the gate closes is thrown away.

Top module: `serial_char_rx`

## Requirements
- R1: After reset, rx_valid, rx_frame_err and rx_break are 0 and rx_data is 0x00.
- R2: With sync_mode=0 and a high stop bit, each character yields exactly one rx_valid pulse. The data is assembled least significant bit first, and rx_frame_err=0 and rx_break=0.
- R3: os_sel selects the oversampling ratio in asynchronous mode: 2'b00 is 8, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 16 clocks per bit.
- R4: In asynchronous mode, a start bit is accepted only if the line still reads low at mid-bit. A low pulse shorter than half a bit produces no character.
- R5: In normal operation, a low stop bit gives rx_frame_err=1. The receiver then ignores the line until it has read high, and only after that does it look for the next start bit.
- R6: In normal operation, a character with all-zero data and a low stop bit gives rx_break=1 together with rx_frame_err=1.
- R7: With sync_mode=1, every clock samples one bit, so back-to-back characters with high stop bits are received with no idle time between them.
- R8: With sync_mode=1 and zero_stop_en=1, a low stop bit gives rx_frame_err=1. The very next bit is taken as data bit 0 of the following character.
- R9: In stopless mode, rx_break=1 is reported only on the second of two consecutive all-zero characters whose stop bit is low. The first of them has rx_break=0.
- R10: zero_stop_en has no effect when sync_mode=0, and normal-mode framing and break rules apply.
- R11: While gate_en and tx_active are both 1, no character is reported. A character in progress is discarded, and reception resumes at the first start bit after the line has read high with the gate open. With gate_en=0, tx_active has no effect.
- R12: rx_valid lasts one clock, and rx_frame_err and rx_break are 0 whenever rx_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; oversampling tick in asynchronous mode, bit clock in synchronous mode |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, idle high |
| sync_mode | input | 1 | 1 = one bit per clock, 0 = oversampled |
| os_sel | input | 2 | Oversampling ratio select (00=8, 01=16, 10=32, 11=16) |
| zero_stop_en | input | 1 | Tolerate missing stop bits (used only with sync_mode=1) |
| gate_en | input | 1 | Enables gating of reception by tx_active |
| tx_active | input | 1 | Local transmitter is driving the line |
| rx_data | output | 8 | Last received character |
| rx_valid | output | 1 | One-cycle pulse marking a new character |
| rx_frame_err | output | 1 | Stop bit was low for this character |
| rx_break | output | 1 | Break condition for this character |

## Verification
In stopless mode, one sample does two jobs at once. The same low stop-bit sample raises the framing error on the character being closed and also acts as the start bit of the next character. The bench provokes this by sending characters with no idle time and a low bit at the stop position, then by sending two all-zero stopless characters in a row. It judges the result by checking that the second character's data bits are recovered intact, with no bit lost or shifted. It also checks that break is set only on the second all-zero character.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // Largest oversampling ratio the bit timer must count.
  localparam int unsigned OS_MAX = 32;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_HOLD  = 3'd4
  } rx_state_e;

  // Clocks per bit for each value of the ratio select.
  function automatic int unsigned os_ratio(input logic [1:0] sel);
    case (sel)
      2'b00:   return 8;
      2'b10:   return 32;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '1;
    else     stg <= {stg[N-2:0], din};
  end

  assign dout = stg[N-1];
endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_mode,
  input  logic [1:0] os_sel,
  input  logic       arm,
  input  logic       run,
  output logic       strobe
);
  import srx_pkg::*;

  localparam int unsigned CNT_W = $clog2(OS_MAX);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] full_m1;
  logic [CNT_W-1:0] half_m1;

  assign full_m1 = CNT_W'(os_ratio(os_sel) - 1);
  assign half_m1 = CNT_W'((os_ratio(os_sel) / 2) - 1);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (arm)            cnt <= half_m1;
    else if (run) begin
      if (cnt == '0)         cnt <= full_m1;
      else                   cnt <= cnt - 1'b1;
    end
  end

  assign strobe = sync_mode | (run & (cnt == '0));
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxs,
  input  logic              strobe,
  input  logic              sync_mode,
  input  logic              zero_stop_en,
  input  logic              gate,
  output logic              arm,
  output logic              run,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              rx_break
);
  import srx_pkg::*;

  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_e         state;
  logic [IDX_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              zflag;
  logic              zs_act;

  assign zs_act = sync_mode & zero_stop_en;
  assign arm    = (state == ST_IDLE) & ~rxs & ~gate & ~sync_mode;
  assign run    = (state == ST_START) | (state == ST_DATA) | (state == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      bit_idx      <= '0;
      shreg        <= '0;
      zflag        <= 1'b0;
      rx_data      <= '0;
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_break     <= 1'b0;
    end else begin
      rx_valid     <= 1'b0;
      rx_frame_err <= 1'b0;
      rx_break     <= 1'b0;
      if (gate) begin
        state <= ST_HOLD;
        zflag <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (!rxs) begin
              bit_idx <= '0;
              state   <= sync_mode ? ST_DATA : ST_START;
            end
          end
          ST_START: begin
            if (strobe) state <= rxs ? ST_IDLE : ST_DATA;
          end
          ST_DATA: begin
            if (strobe) begin
              shreg <= {rxs, shreg[DATA_W-1:1]};
              if (bit_idx == IDX_W'(DATA_W - 1)) state <= ST_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end
          end
          ST_STOP: begin
            if (strobe) begin
              rx_valid     <= 1'b1;
              rx_data      <= shreg;
              rx_frame_err <= ~rxs;
              rx_break     <= ~rxs & (shreg == '0) & (~zs_act | zflag);
              zflag        <= zs_act & ~rxs & (shreg == '0);
              bit_idx      <= '0;
              if (rxs)         state <= ST_IDLE;
              else if (zs_act) state <= ST_DATA;
              else             state <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (rxs) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R12
  AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> !(rx_frame_err || rx_break)); // R12
  AST_BREAK_IS_ZERO_FERR: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_break) |-> (rx_data == '0 && rx_frame_err)); // R6
  AST_GATE_SILENT: assert property (@(posedge clk) disable iff (rst)
    gate |=> !rx_valid); // R11
  AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !rxs) |=> (state == ST_HOLD)); // R5
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              sync_mode,
  input  logic [1:0]        os_sel,
  input  logic              zero_stop_en,
  input  logic              gate_en,
  input  logic              tx_active,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_frame_err,
  output logic              rx_break
);
  logic rxs;
  logic strobe;
  logic arm;
  logic run;
  logic gate;

  assign gate = gate_en & tx_active;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (rxs)
  );

  srx_bit_timer u_timer (
    .clk       (clk),
    .rst       (rst),
    .sync_mode (sync_mode),
    .os_sel    (os_sel),
    .arm       (arm),
    .run       (run),
    .strobe    (strobe)
  );

  srx_deframer #(.DATA_W(DATA_W)) u_deframer (
    .clk          (clk),
    .rst          (rst),
    .rxs          (rxs),
    .strobe       (strobe),
    .sync_mode    (sync_mode),
    .zero_stop_en (zero_stop_en),
    .gate         (gate),
    .arm          (arm),
    .run          (run),
    .rx_data      (rx_data),
    .rx_valid     (rx_valid),
    .rx_frame_err (rx_frame_err),
    .rx_break     (rx_break)
  );
endmodule

// File: tb/serial_char_rx_tb_top.sv
module serial_char_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic       sync_mode = 1'b0;
  logic [1:0] os_sel = 2'b01;
  logic       zero_stop_en = 1'b0;
  logic       gate_en = 1'b0;
  logic       tx_active = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_frame_err;
  logic       rx_break;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] cap_d [16];
  logic       cap_f [16];
  logic       cap_b [16];
  int         ncap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_char_rx dut_i (
    .clk(clk), .rst(rst), .rxd(rxd), .sync_mode(sync_mode), .os_sel(os_sel),
    .zero_stop_en(zero_stop_en), .gate_en(gate_en), .tx_active(tx_active),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_break(rx_break)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (ncap < 16) begin
        cap_d[ncap] = rx_data;
        cap_f[ncap] = rx_frame_err;
        cap_b[ncap] = rx_break;
      end
      ncap = ncap + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp < %0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: act 0x%0h exp 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_caps();
    ncap = 0;
  endtask

  task automatic put_bit(input bit b, input int n);
    rxd = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    put_bit(1'b1, n);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit stop, input int n);
    put_bit(1'b0, n);
    for (int i = 0; i < 8; i++) put_bit(d[i], n);
    put_bit(stop, n);
  endtask

  task automatic send_data_only(input logic [7:0] d, input bit stop);
    for (int i = 0; i < 8; i++) put_bit(d[i], 1);
    put_bit(stop, 1);
  endtask

  task automatic expect_cap(input int idx, input string req, input logic [7:0] d,
                            input bit f, input bit b);
    check(cap_d[idx] == d, req, $sformatf("char%0d data", idx), cap_d[idx], d);
    check(cap_f[idx] == f, req, $sformatf("char%0d frame_err", idx), cap_f[idx], f);
    check(cap_b[idx] == b, req, $sformatf("char%0d break", idx), cap_b[idx], b);
  endtask

  task automatic t_reset();
    check(rx_valid == 1'b0, "R1", "rx_valid", rx_valid, 0);
    check(rx_data == 8'h00, "R1", "rx_data", rx_data, 0);
    check(rx_frame_err == 1'b0, "R1", "rx_frame_err", rx_frame_err, 0);
    check(rx_break == 1'b0, "R1", "rx_break", rx_break, 0);
  endtask

  task automatic t_async_basic();
    sync_mode = 0; os_sel = 2'b01; clear_caps();
    send_frame(8'hA5, 1, 16);
    send_frame(8'h3C, 1, 16);
    idle(40);
    check(ncap == 2, "R2/R12", "valid count", ncap, 2);
    expect_cap(0, "R2", 8'hA5, 0, 0);
    expect_cap(1, "R2", 8'h3C, 0, 0);
  endtask

  task automatic t_os_rates();
    sync_mode = 0; clear_caps();
    os_sel = 2'b00; send_frame(8'h81, 1, 8);  idle(40);
    os_sel = 2'b10; send_frame(8'h5E, 1, 32); idle(70);
    os_sel = 2'b11; send_frame(8'h24, 1, 16); idle(40);
    check(ncap == 3, "R3", "valid count", ncap, 3);
    expect_cap(0, "R3", 8'h81, 0, 0);
    expect_cap(1, "R3", 8'h5E, 0, 0);
    expect_cap(2, "R3", 8'h24, 0, 0);
    os_sel = 2'b01;
  endtask

  task automatic t_glitch();
    sync_mode = 0; os_sel = 2'b01; clear_caps();
    put_bit(1'b0, 3);
    idle(60);
    check(ncap == 0, "R4", "short low pulse count", ncap, 0);
    send_frame(8'h66, 1, 16);
    idle(40);
    check(ncap == 1, "R4", "count after glitch", ncap, 1);
    expect_cap(0, "R4", 8'h66, 0, 0);
  endtask

  task automatic t_async_ferr();
    sync_mode = 0; os_sel = 2'b01; clear_caps();
    send_frame(8'hA5, 0, 16);
    put_bit(1'b0, 40);
    idle(20);
    send_frame(8'h11, 1, 16);
    idle(40);
    check(ncap == 2, "R5", "valid count", ncap, 2);
    expect_cap(0, "R5", 8'hA5, 1, 0);
    expect_cap(1, "R5", 8'h11, 0, 0);
  endtask

  task automatic t_async_break(input bit zs);
    sync_mode = 0; os_sel = 2'b01; zero_stop_en = zs; clear_caps();
    send_frame(8'h00, 0, 16);
    put_bit(1'b0, 30);
    idle(20);
    send_frame(8'h77, 1, 16);
    idle(40);
    check(ncap == 2, zs ? "R10" : "R6", "valid count", ncap, 2);
    expect_cap(0, zs ? "R10" : "R6", 8'h00, 1, 1);
    expect_cap(1, zs ? "R10" : "R6", 8'h77, 0, 0);
    zero_stop_en = 0;
  endtask

  task automatic t_sync_basic();
    sync_mode = 1; zero_stop_en = 0; clear_caps();
    send_frame(8'hC3, 1, 1);
    send_frame(8'h5A, 1, 1);
    idle(10);
    check(ncap == 2, "R7", "valid count", ncap, 2);
    expect_cap(0, "R7", 8'hC3, 0, 0);
    expect_cap(1, "R7", 8'h5A, 0, 0);
  endtask

  task automatic t_zero_stop();
    sync_mode = 1; zero_stop_en = 1; clear_caps();
    put_bit(1'b0, 1);
    send_data_only(8'h5A, 0);
    send_data_only(8'h3C, 1);
    idle(10);
    check(ncap == 2, "R8", "valid count", ncap, 2);
    expect_cap(0, "R8", 8'h5A, 1, 0);
    expect_cap(1, "R8", 8'h3C, 0, 0);
    zero_stop_en = 0;
  endtask

  task automatic t_zs_break();
    sync_mode = 1; zero_stop_en = 1; clear_caps();
    put_bit(1'b0, 1);
    send_data_only(8'h00, 0);
    send_data_only(8'h00, 0);
    send_data_only(8'hFF, 1);
    idle(10);
    check(ncap == 3, "R9", "valid count", ncap, 3);
    expect_cap(0, "R9", 8'h00, 1, 0);
    expect_cap(1, "R9", 8'h00, 1, 1);
    expect_cap(2, "R9", 8'hFF, 0, 0);
    zero_stop_en = 0;
  endtask

  task automatic t_gate();
    sync_mode = 0; os_sel = 2'b01; clear_caps();
    gate_en = 1; tx_active = 1;
    send_frame(8'h55, 1, 16);
    idle(40);
    check(ncap == 0, "R11", "count while gated", ncap, 0);
    tx_active = 0;
    idle(4);
    // 0xF0 with the gate closing over bits 1..2
    put_bit(1'b0, 16);
    put_bit(1'b0, 16);
    tx_active = 1;
    put_bit(1'b0, 16);
    put_bit(1'b0, 16);
    tx_active = 0;
    put_bit(1'b0, 16);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 16);
    put_bit(1'b1, 16);
    idle(20);
    check(ncap == 0, "R11", "partial char discarded", ncap, 0);
    send_frame(8'h3C, 1, 16);
    idle(40);
    check(ncap == 1, "R11", "count after release", ncap, 1);
    expect_cap(0, "R11", 8'h3C, 0, 0);
    gate_en = 0; tx_active = 1; clear_caps();
    send_frame(8'h9D, 1, 16);
    idle(40);
    check(ncap == 1, "R11", "count with gate disabled", ncap, 1);
    expect_cap(0, "R11", 8'h9D, 0, 0);
    tx_active = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(5);
    t_async_basic();
    t_os_rates();
    t_glitch();
    t_async_ferr();
    t_async_break(1'b0);
    t_async_break(1'b1);
    t_sync_basic();
    t_zero_stop();
    t_zs_break();
    sync_mode = 0;
    idle(5);
    t_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule